// File: doc/BRIEF.md
# Two-Channel DC Offset Trim Filter

This block removes a slowly varying DC offset from a stream of decimated stereo audio samples. Each sample is a 24-bit two's-complement value. Left and right each keep their own offset estimate in an accumulator with extra fraction bits. The estimate follows the input through a leaky integrator that moves one 8192th of the gap on every sample. The current integer part of the estimate is subtracted from each sample. The result is clipped to the 24-bit signed range and registered.

A freeze input stops the estimate from updating, and the stored offset is still subtracted. This supports offset calibration at system level: the block runs unfrozen until the estimate has settled, and then it is frozen so that the captured offset is held for later samples. When freeze is released, tracking continues from the held value. With the default settings at a 48 kHz sample rate, the corner frequency is close to 1 Hz. Settling takes in the order of 10^5 samples, and the response scales with the sample rate.

Top module: `dc_trim_hpf`

## Requirements
- R1: `out_valid` is high in exactly the clock that follows a clock in which `in_valid` was high, and low otherwise.
- R2: For each accepted sample x, the channel output equals x minus the offset held before that sample's update, and the offset is floor(acc / 2^16).
- R3: For each accepted sample with `freeze` low, the accumulator becomes acc + ((x·2^16 − acc) >>> 13), where >>> is an arithmetic shift (floor).
- R4: For a sample accepted with `freeze` high, the accumulator keeps its value, and the held offset is still subtracted from that sample.
- R5: The difference is saturated. Results above 8388607 give 8388607, and results below −8388608 give −8388608. The result never wraps.
- R6: When `freeze` drops, tracking restarts from the held accumulator value and not from zero.
- R7: A synchronous reset (`rst` high) clears both accumulators, `out_valid` and both outputs to zero.
- R8: The left and right channels have separate accumulators. A sample on one channel never changes the other channel's offset.
- R9: In a clock in which `in_valid` is low, the accumulators and both output samples keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe for both channels |
| freeze | input | 1 | High: hold the offset estimates; low: track |
| in_left | input | 24 | Left sample, two's complement |
| in_right | input | 24 | Right sample, two's complement |
| out_valid | output | 1 | Corrected-sample strobe |
| out_left | output | 24 | Corrected left sample |
| out_right | output | 24 | Corrected right sample |

## Verification
Every result arrives one clock after the sample that caused it. The corrected value and its strobe are registered in the same edge in which the accumulator takes its new value. A sample's effect on the offset therefore first shows in the output of the next accepted sample. The bench drives each sample on a falling edge and checks the outputs at the next falling edge. It updates its own accumulator model only after it has computed the expected output from the old offset, so a model that updated first would give the wrong offset.

// File: rtl/dct_pkg.sv
`timescale 1ns/1ps
package dct_pkg;
   localparam int unsigned DCT_SAMPLE_W = 24;
   localparam int unsigned DCT_FRAC_W   = 16;
   localparam int unsigned DCT_SHIFT    = 13;
   localparam int unsigned DCT_CHANNELS = 2;
endpackage

// File: rtl/dct_offset_track.sv
`timescale 1ns/1ps
module dct_offset_track #(
   parameter int unsigned SAMPLE_W = 24,
   parameter int unsigned FRAC_W   = 16,
   parameter int unsigned SHIFT    = 13
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                in_valid,
   input  logic                freeze,
   input  logic [SAMPLE_W-1:0] x,
   output logic [SAMPLE_W-1:0] off
);
   localparam int unsigned ACC_W = SAMPLE_W + FRAC_W;

   logic signed [ACC_W-1:0] acc_q;
   logic signed [ACC_W:0]   target, diff, step;
   logic        [ACC_W-1:0] acc_next;
   logic                    unused_step_msb;

   // sample placed on the accumulator's fixed-point grid
   assign target   = {x[SAMPLE_W-1], x, {FRAC_W{1'b0}}};
   assign diff     = target - {acc_q[ACC_W-1], acc_q};
   assign step     = diff >>> SHIFT;
   assign acc_next = acc_q + step[ACC_W-1:0];
   assign unused_step_msb = step[ACC_W];

   always_ff @(posedge clk) begin
      if (rst)                     acc_q <= '0;
      else if (in_valid && !freeze) acc_q <= acc_next;
   end

   assign off = acc_q[ACC_W-1:FRAC_W];

   // R7: reset empties the estimate
   p_reset_clear_r7: assert property (@(posedge clk) rst |=> acc_q == '0);
   // R4: a frozen sample leaves the estimate alone
   p_freeze_hold_r4: assert property (@(posedge clk) disable iff (rst)
      (in_valid && freeze) |=> $stable(acc_q));
   // R9: no strobe, no change
   p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(acc_q));
endmodule

// File: rtl/dct_sat_sub.sv
`timescale 1ns/1ps
module dct_sat_sub #(
   parameter int unsigned W = 24
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] y
);
   logic [W:0] d;
   logic       ovf;

   assign d   = {a[W-1], a} - {b[W-1], b};
   assign ovf = d[W] ^ d[W-1];

   always_comb begin
      if (!ovf)     y = d[W-1:0];
      else if (d[W]) y = {1'b1, {(W-1){1'b0}}};
      else           y = {1'b0, {(W-1){1'b1}}};
   end
endmodule

// File: rtl/dct_lane.sv
`timescale 1ns/1ps
module dct_lane #(
   parameter int unsigned SAMPLE_W = 24,
   parameter int unsigned FRAC_W   = 16,
   parameter int unsigned SHIFT    = 13
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                in_valid,
   input  logic                freeze,
   input  logic [SAMPLE_W-1:0] x,
   output logic [SAMPLE_W-1:0] y
);
   logic [SAMPLE_W-1:0] off, trimmed, y_q;

   dct_offset_track #(.SAMPLE_W(SAMPLE_W), .FRAC_W(FRAC_W), .SHIFT(SHIFT)) u_track (
      .clk(clk), .rst(rst), .in_valid(in_valid), .freeze(freeze), .x(x), .off(off));

   dct_sat_sub #(.W(SAMPLE_W)) u_sub (.a(x), .b(off), .y(trimmed));

   always_ff @(posedge clk) begin
      if (rst)           y_q <= '0;
      else if (in_valid) y_q <= trimmed;
   end
   assign y = y_q;

   // R5: a non-negative minus a non-positive stays non-negative
   p_no_wrap_pos_r5: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !x[SAMPLE_W-1] && (off[SAMPLE_W-1] || off == '0)) |=> !y[SAMPLE_W-1]);
   // R5: a negative minus a non-negative stays negative
   p_no_wrap_neg_r5: assert property (@(posedge clk) disable iff (rst)
      (in_valid && x[SAMPLE_W-1] && !off[SAMPLE_W-1]) |=> y[SAMPLE_W-1]);
   // R2: with a zero estimate the sample passes through untouched
   p_pass_zero_r2: assert property (@(posedge clk) disable iff (rst)
      (in_valid && off == '0) |=> y == $past(x));
endmodule

// File: rtl/dc_trim_hpf.sv
`timescale 1ns/1ps
module dc_trim_hpf #(
   parameter int unsigned SAMPLE_W = dct_pkg::DCT_SAMPLE_W,
   parameter int unsigned FRAC_W   = dct_pkg::DCT_FRAC_W,
   parameter int unsigned SHIFT    = dct_pkg::DCT_SHIFT
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                in_valid,
   input  logic                freeze,
   input  logic [SAMPLE_W-1:0] in_left,
   input  logic [SAMPLE_W-1:0] in_right,
   output logic                out_valid,
   output logic [SAMPLE_W-1:0] out_left,
   output logic [SAMPLE_W-1:0] out_right
);
   localparam int unsigned NCH = dct_pkg::DCT_CHANNELS;

   if (FRAC_W < 16)     begin : g_bad_frac  $error("FRAC_W must be at least 16"); end
   if (SHIFT < 1)        begin : g_bad_shift $error("SHIFT must be at least 1"); end
   if (SHIFT > FRAC_W + SAMPLE_W - 1) begin : g_big_shift $error("SHIFT too large"); end
   if (SAMPLE_W < 2)     begin : g_bad_w     $error("SAMPLE_W must be at least 2"); end

   logic [SAMPLE_W-1:0] lane_in  [NCH];
   logic [SAMPLE_W-1:0] lane_out [NCH];
   logic                valid_q;

   assign lane_in[0] = in_left;
   assign lane_in[1] = in_right;

   for (genvar c = 0; c < NCH; c++) begin : g_lane
      dct_lane #(.SAMPLE_W(SAMPLE_W), .FRAC_W(FRAC_W), .SHIFT(SHIFT)) u_lane (
         .clk(clk), .rst(rst), .in_valid(in_valid), .freeze(freeze),
         .x(lane_in[c]), .y(lane_out[c]));
   end

   always_ff @(posedge clk) begin
      if (rst) valid_q <= 1'b0;
      else     valid_q <= in_valid;
   end

   assign out_valid = valid_q;
   assign out_left  = lane_out[0];
   assign out_right = lane_out[1];

   // R1: strobe lags by one clock, both ways
   p_valid_lag_r1: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid);
   p_valid_quiet_r1: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid);
   // R9: outputs hold while idle
   p_out_hold_r9: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> ($stable(out_left) && $stable(out_right)));
   // R7: reset clears the strobe and samples
   p_reset_out_r7: assert property (@(posedge clk)
      rst |=> (!out_valid && out_left == '0 && out_right == '0));
endmodule

// File: tb/sim_dc_trim_hpf.sv
`timescale 1ns/1ps
module sim_dc_trim_hpf;
   localparam int F = 16;
   localparam int S = 13;
   localparam int MAXV = 8388607;
   localparam int MINV = -8388608;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic        rst, in_valid, freeze, out_valid;
   logic [23:0] in_left, in_right, out_left, out_right;

   dc_trim_hpf u0 (.clk(clk), .rst(rst), .in_valid(in_valid), .freeze(freeze),
      .in_left(in_left), .in_right(in_right), .out_valid(out_valid),
      .out_left(out_left), .out_right(out_right));

   longint acc_l, acc_r;
   logic [23:0] exp_l, exp_r;
   int n_chk = 0, n_bad = 0;
   bit done = 0;

   function automatic logic [23:0] sat24(longint v);
      if (v > MAXV) return 24'(MAXV);
      if (v < MINV) return 24'(MINV);
      return v[23:0];
   endfunction

   function automatic longint trk(longint acc, longint x);
      longint d;
      d = (x <<< F) - acc;
      return acc + (d >>> S);
   endfunction

   task automatic chk(string req, logic [23:0] act, logic [23:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, $signed(act), $signed(exp));
      end
   endtask

   // one clock: drive at falling edge, check at the next falling edge
   task automatic step(bit v, int l, int r, bit fz, string req);
      in_valid = v; freeze = fz; in_left = l[23:0]; in_right = r[23:0];
      if (v) begin
         exp_l = sat24(longint'(l) - (acc_l >>> F));
         exp_r = sat24(longint'(r) - (acc_r >>> F));
         if (!fz) begin acc_l = trk(acc_l, l); acc_r = trk(acc_r, r); end
      end
      @(posedge clk); @(negedge clk);
      chk("R1 valid", {23'd0, out_valid}, {23'd0, v});
      chk(req, out_left, exp_l);
      chk(req, out_right, exp_r);
   endtask

   task automatic do_reset();
      rst = 1; in_valid = 0; freeze = 0; in_left = '0; in_right = '0;
      repeat (3) @(negedge clk);
      rst = 0;
      acc_l = 0; acc_r = 0; exp_l = '0; exp_r = '0;
      chk("R7 reset valid", {23'd0, out_valid}, 24'd0);
      chk("R7 reset left", out_left, 24'd0);
      chk("R7 reset right", out_right, 24'd0);
   endtask

   function automatic int rnd24();
      return int'($urandom) >>> 8;
   endfunction

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20231));
      @(negedge clk);
      do_reset();
      // R2 first sample passes through with zero offset
      step(1, 1234567, -7654321, 0, "R2 zero offset");
      // R9 idle clocks hold outputs
      for (int i = 0; i < 5; i++) step(0, rnd24(), rnd24(), 0, "R9 hold");
      // R3 random tracking with gaps
      for (int i = 0; i < 3000; i++)
         step(($urandom % 4) != 0, rnd24(), rnd24(), 0, "R3 random track");
      // R8 channels differ: large DC on left only, right near zero
      for (int i = 0; i < 30000; i++)
         step(1, 3000000 + (rnd24() >>> 10), (rnd24() >>> 12), 0, "R8 separate channels");
      // R4 frozen: offset held and still subtracted
      for (int i = 0; i < 500; i++)
         step(($urandom % 2) != 0, rnd24(), rnd24(), 1, "R4 frozen");
      for (int i = 0; i < 4; i++) step(1, 3000000, 0, 1, "R4 constant while frozen");
      // R6 resume from held value
      for (int i = 0; i < 2000; i++) step(1, -2000000, 500000, 0, "R6 resume");
      // R5 saturation both directions
      do_reset();
      for (int i = 0; i < 4000; i++) step(1, MAXV, MINV, 0, "R5 build offsets");
      step(1, MINV, MAXV, 1, "R5 saturate");
      step(1, MINV, MAXV, 0, "R5 saturate tracking");
      step(1, MAXV, MINV, 0, "R5 in range");
      // R7 reset mid-run clears estimate
      do_reset();
      step(1, -42, 42, 0, "R7 fresh after reset");
      for (int i = 0; i < 200; i++) step(1, rnd24(), rnd24(), ($urandom % 3) == 0, "R3 mixed freeze");
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule